// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the register side of a multi-channel DMA controller. It serves up to eight channels. A word-addressed slave port reads and writes five 32-bit words per channel: source address, destination address, link pointer, control and configuration. The port also reaches a small global area. That area holds the interrupt latches, the clear and status views, a bitmap of the enabled channels and a three-bit controller configuration. A read-only identification block sits at the top of the 4 KiB window.

The transfer engine sits beside this block. It reports events through one-cycle pulses: a terminal-count pulse, an error pulse, and a done pulse that drops a channel's enable bit. Each raw event sets a latch. The latch is masked by two bits of the owning channel's configuration word. The masked results are combined into one registered interrupt line.

A read request is taken in one cycle. Its data appears on `busRdata` in the following cycle.

Top module: `dma_csr_top`

## Requirements
- R1: After reset every register and latch is zero. A write to byte offset 0x100 + 32*c + 4*w stores the data in word w of channel c: 0 source, 1 destination, 2 link, 3 control, 4 configuration. A read of the same offset returns that data on `busRdata` one cycle later. `busRdata` is zero in any cycle that follows no read.
- R2: An access to a channel index c >= NUM_CH, or to word 5, 6 or 7 of any channel block, has no effect and reads as zero.
- R3: A 1 on bit c of `engTcSet` or `engErrSet` sets that channel's raw terminal-count or raw error latch. Offset 0x014 reads the raw terminal-count latches and offset 0x018 reads the raw error latches, with bit c belonging to channel c.
- R4: Bit 15 of a channel's configuration word masks its terminal-count latch, and bit 14 masks its error latch. Offset 0x004 reads the masked terminal-count bits and offset 0x00C reads the masked error bits. Offset 0x000 reads the OR of the two.
- R5: A write to 0x008 clears each raw terminal-count latch whose data bit is 1. A write to 0x010 does the same for the error latches.
- R6: When a set pulse and a clear write hit the same latch bit in one cycle, the bit ends up set.
- R7: Offset 0x01C reads a bitmap in which bit c is bit 0 of channel c's configuration word. A pulse on `engChanDone[c]` clears that bit, even when a bus write to the same word lands in the same cycle.
- R8: Offset 0x030 stores data bits [2:0] and reads them back, with all other bits zero. `ctlEn` follows stored bit 0.
- R9: Offsets 0xFE0 to 0xFFC read one identification byte per word, in this order: 0x80 (0x81 when NUM_CH is not 8), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R10: `irqOut` is a register. It is high in the cycle after any masked terminal-count or masked error bit is set, and low in the cycle after none is set.
- R11: Any other offset reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset; bits [1:0] are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| engTcSet | input | NUM_CH | Terminal-count event pulses from the engine |
| engErrSet | input | NUM_CH | Error event pulses from the engine |
| engChanDone | input | NUM_CH | Channel-disable pulses from the engine |
| irqOut | output | 1 | Registered combined interrupt |
| ctlEn | output | 1 | Controller enable bit of the global configuration |

## Verification
The assertions assume that the event pulses are synchronous to `clk` and already filtered by the engine. They also assume that the bus makes at most one access per cycle and holds no request across reset. The bench drives every input on the falling edge, one access per request cycle. It includes deliberate collisions: a set pulse against a clear write, and a done pulse against a configuration write. A behavioural model is advanced on each rising edge and compared with `busRdata` and `irqOut` on every falling edge. The bench builds the block with six channels, so accesses to channel indices above the count can be exercised.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int CH_WORDS = 5;
  localparam int IDX_W    = 3;
  localparam int GCFG_W   = 3;

  localparam logic [IDX_W-1:0] WORD_CFG = 3'd4;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_ERRM_BIT  = 14;
  localparam int CFG_TCM_BIT   = 15;

  // global word indices (offset[7:2])
  localparam logic [5:0] GW_IRQ_ALL = 6'd0;
  localparam logic [5:0] GW_TC      = 6'd1;
  localparam logic [5:0] GW_TC_CLR  = 6'd2;
  localparam logic [5:0] GW_ERR     = 6'd3;
  localparam logic [5:0] GW_ERR_CLR = 6'd4;
  localparam logic [5:0] GW_RAW_TC  = 6'd5;
  localparam logic [5:0] GW_RAW_ERR = 6'd6;
  localparam logic [5:0] GW_ENABLED = 6'd7;
  localparam logic [5:0] GW_CFG     = 6'd12;

  typedef enum logic [3:0] {
    RD_NONE, RD_CHAN, RD_IRQ_ALL, RD_TC, RD_ERR,
    RD_RAW_TC, RD_RAW_ERR, RD_ENABLED, RD_CFG, RD_ID
  } rdsrc_e;

  typedef struct packed {
    logic             chWe;
    logic [IDX_W-1:0] chIdx;
    logic [IDX_W-1:0] chWord;   // also identification byte index
    logic             tcClr;
    logic             errClr;
    logic             cfgWe;
    rdsrc_e           rdSrc;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [IDX_W-1:0] i, input logic eight);
    case (i)
      3'd0:    idByte = eight ? 8'h80 : 8'h81;
      3'd1:    idByte = 8'h10;
      3'd2:    idByte = 8'h04;
      3'd3:    idByte = 8'h0A;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  logic [IDX_W-1:0] addrIdx;
  logic [IDX_W-1:0] addrWord;
  logic [5:0]       globWord;
  logic             inChan;
  logic             inId;
  logic             inGlob;
  logic             chanOk;
  logic             unusedAddrLsb;

  assign addrIdx       = busAddr[7:5];
  assign addrWord      = busAddr[4:2];
  assign globWord      = busAddr[7:2];
  assign inChan        = (busAddr[11:8] == 4'h1);
  assign inId          = (busAddr[11:5] == 7'h7F);
  assign inGlob        = (busAddr[11:8] == 4'h0);
  assign chanOk        = (32'(addrIdx) < NUM_CH) && (32'(addrWord) < CH_WORDS);
  assign unusedAddrLsb = ^busAddr[1:0];

  always_comb begin
    stb        = '0;
    stb.rdSrc  = RD_NONE;
    stb.chIdx  = addrIdx;
    stb.chWord = addrWord;
    if (busSel) begin
      if (inChan) begin
        if (chanOk) begin
          if (busWrite) stb.chWe  = 1'b1;
          else          stb.rdSrc = RD_CHAN;
        end
      end else if (inId) begin
        if (!busWrite) stb.rdSrc = RD_ID;
      end else if (inGlob) begin
        if (busWrite) begin
          case (globWord)
            GW_TC_CLR:  stb.tcClr  = 1'b1;
            GW_ERR_CLR: stb.errClr = 1'b1;
            GW_CFG:     stb.cfgWe  = 1'b1;
            default:    ;
          endcase
        end else begin
          case (globWord)
            GW_IRQ_ALL: stb.rdSrc = RD_IRQ_ALL;
            GW_TC:      stb.rdSrc = RD_TC;
            GW_ERR:     stb.rdSrc = RD_ERR;
            GW_RAW_TC:  stb.rdSrc = RD_RAW_TC;
            GW_RAW_ERR: stb.rdSrc = RD_RAW_ERR;
            GW_ENABLED: stb.rdSrc = RD_ENABLED;
            GW_CFG:     stb.rdSrc = RD_CFG;
            default:    ;
          endcase
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.chWe, stb.tcClr, stb.errClr, stb.cfgWe})); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (stb.rdSrc == RD_NONE && !stb.chWe && !stb.cfgWe)); // R1

endmodule

// File: rtl/dma_csr_dpath.sv
module dma_csr_dpath
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] engTcSet,
  input  logic [NUM_CH-1:0] engErrSet,
  input  logic [NUM_CH-1:0] engChanDone,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              ctlEn
);

  localparam int PAD_W = DATA_W - NUM_CH;

  logic [DATA_W-1:0] chRdWord [NUM_CH];
  logic [NUM_CH-1:0] tcMask;
  logic [NUM_CH-1:0] errMask;
  logic [NUM_CH-1:0] chEnBits;
  logic [NUM_CH-1:0] tcRaw;
  logic [NUM_CH-1:0] errRaw;
  logic [NUM_CH-1:0] tcMasked;
  logic [NUM_CH-1:0] errMasked;
  logic [NUM_CH-1:0] tcClrBits;
  logic [NUM_CH-1:0] errClrBits;
  logic [GCFG_W-1:0] gCfg;
  logic [DATA_W-1:0] rdNext;
  logic              irqQ;

  // per-channel register blocks
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] words [CH_WORDS];
    logic              hit;

    assign hit = stb.chWe && (stb.chIdx == IDX_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < CH_WORDS; w++) words[w] <= '0;
      end else begin
        if (hit) words[stb.chWord] <= wdata;
        if (engChanDone[c]) words[WORD_CFG][CFG_EN_BIT] <= 1'b0;
      end
    end

    assign chRdWord[c] = (32'(stb.chWord) < CH_WORDS) ? words[stb.chWord] : '0;
    assign tcMask[c]   = words[WORD_CFG][CFG_TCM_BIT];
    assign errMask[c]  = words[WORD_CFG][CFG_ERRM_BIT];
    assign chEnBits[c] = words[WORD_CFG][CFG_EN_BIT];

    AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
      engChanDone[c] |=> !chEnBits[c]); // R7

    AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      engTcSet[c] |=> tcRaw[c]); // R6

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      engErrSet[c] |=> errRaw[c]); // R6

    AST_TC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      (stb.tcClr && wdata[c] && !engTcSet[c]) |=> !tcRaw[c]); // R5

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      (stb.errClr && wdata[c] && !engErrSet[c]) |=> !errRaw[c]); // R5
  end

  // interrupt latches
  assign tcClrBits  = stb.tcClr  ? wdata[NUM_CH-1:0] : '0;
  assign errClrBits = stb.errClr ? wdata[NUM_CH-1:0] : '0;
  assign tcMasked   = tcRaw & tcMask;
  assign errMasked  = errRaw & errMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcRaw  <= '0;
      errRaw <= '0;
      irqQ   <= 1'b0;
      gCfg   <= '0;
    end else begin
      tcRaw  <= (tcRaw & ~tcClrBits) | engTcSet;
      errRaw <= (errRaw & ~errClrBits) | engErrSet;
      irqQ   <= (|tcMasked) | (|errMasked);
      if (stb.cfgWe) gCfg <= wdata[GCFG_W-1:0];
    end
  end

  // read mux, registered
  always_comb begin
    rdNext = '0;
    unique case (stb.rdSrc)
      RD_CHAN:    rdNext = chRdWord[stb.chIdx];
      RD_IRQ_ALL: rdNext = {{PAD_W{1'b0}}, tcMasked | errMasked};
      RD_TC:      rdNext = {{PAD_W{1'b0}}, tcMasked};
      RD_ERR:     rdNext = {{PAD_W{1'b0}}, errMasked};
      RD_RAW_TC:  rdNext = {{PAD_W{1'b0}}, tcRaw};
      RD_RAW_ERR: rdNext = {{PAD_W{1'b0}}, errRaw};
      RD_ENABLED: rdNext = {{PAD_W{1'b0}}, chEnBits};
      RD_CFG:     rdNext = {{(DATA_W-GCFG_W){1'b0}}, gCfg};
      RD_ID:      rdNext = {24'h0, idByte(stb.chWord, NUM_CH == 8)};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end

  assign irqOut = irqQ;
  assign ctlEn  = gCfg[0];

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSrc == RD_NONE) |=> (rdata == '0)); // R1

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.chWe || stb.rdSrc == RD_CHAN) |-> (32'(stb.chIdx) < NUM_CH)); // R2

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (tcMasked == '0 && errMasked == '0) |=> !irqOut); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (tcMasked != '0 || errMasked != '0) |=> irqOut); // R10

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWe |=> $stable(gCfg)); // R8

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [11:0]       busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NUM_CH-1:0] engTcSet,
  input  logic [NUM_CH-1:0] engErrSet,
  input  logic [NUM_CH-1:0] engChanDone,
  output logic              irqOut,
  output logic              ctlEn
);

  strobe_t stb;

  initial begin
    assert (NUM_CH >= 1 && NUM_CH <= 8)
      else $error("NUM_CH must be 1..8");
  end

  dma_csr_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  dma_csr_dpath #(.NUM_CH(NUM_CH)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (busWdata),
    .engTcSet    (engTcSet),
    .engErrSet   (engErrSet),
    .engChanDone (engChanDone),
    .rdata       (busRdata),
    .irqOut      (irqOut),
    .ctlEn       (ctlEn)
  );

endmodule

// File: tb/dma_csr_top_tb.sv
`timescale 1ns/1ps
module dma_csr_top_tb;

  localparam int NCH = 6;
  localparam int WATCHDOG = 50000;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busSel = 1'b0;
  logic           busWrite = 1'b0;
  logic [11:0]    busAddr = '0;
  logic [31:0]    busWdata = '0;
  logic [31:0]    busRdata;
  logic [NCH-1:0] engTcSet = '0;
  logic [NCH-1:0] engErrSet = '0;
  logic [NCH-1:0] engChanDone = '0;
  logic           irqOut;
  logic           ctlEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  dma_csr_top #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engTcSet(engTcSet), .engErrSet(engErrSet), .engChanDone(engChanDone),
    .irqOut(irqOut), .ctlEn(ctlEn)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mReg [8][5];
  logic [31:0] mTc, mErr;
  logic [2:0]  mGcfg;
  logic        mIrq;
  logic [31:0] expRd;

  function automatic logic [31:0] tcMaskM();
    logic [31:0] m = 0;
    for (int c = 0; c < NCH; c++) m[c] = mReg[c][4][15];
    return m;
  endfunction

  function automatic logic [31:0] errMaskM();
    logic [31:0] m = 0;
    for (int c = 0; c < NCH; c++) m[c] = mReg[c][4][14];
    return m;
  endfunction

  function automatic logic [7:0] idM(int i);
    case (i)
      0: return (NCH == 8) ? 8'h80 : 8'h81;
      1: return 8'h10;
      2: return 8'h04;
      3: return 8'h0A;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] readM(logic [11:0] a);
    int idx = int'(a[7:5]);
    int w   = int'(a[4:2]);
    int g   = int'(a[7:2]);
    logic [31:0] en = 0;
    if (a >= 12'h100 && a < 12'h200)
      return (idx < NCH && w < 5) ? mReg[idx][w] : 32'h0;
    if (a >= 12'hFE0) return {24'h0, idM(w)};
    if (a < 12'h100) begin
      for (int c = 0; c < NCH; c++) en[c] = mReg[c][4][0];
      case (g)
        0: return (mTc & tcMaskM()) | (mErr & errMaskM());
        1: return mTc & tcMaskM();
        3: return mErr & errMaskM();
        5: return mTc;
        6: return mErr;
        7: return en;
        12: return {29'h0, mGcfg};
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 8; c++) for (int w = 0; w < 5; w++) mReg[c][w] = '0;
      mTc = 0; mErr = 0; mGcfg = 0; mIrq = 0; expRd = 0;
    end else begin
      logic [31:0] clrT, clrE;
      mIrq  = (((mTc & tcMaskM()) | (mErr & errMaskM())) != 0);
      expRd = (busSel && !busWrite) ? readM(busAddr) : 32'h0;
      clrT = 0; clrE = 0;
      if (busSel && busWrite) begin
        if (busAddr >= 12'h100 && busAddr < 12'h200) begin
          if (int'(busAddr[7:5]) < NCH && int'(busAddr[4:2]) < 5)
            mReg[int'(busAddr[7:5])][int'(busAddr[4:2])] = busWdata;
        end else if (busAddr < 12'h100) begin
          case (int'(busAddr[7:2]))
            2:  clrT = busWdata;
            4:  clrE = busWdata;
            12: mGcfg = busWdata[2:0];
            default: ;
          endcase
        end
      end
      mTc  = ((mTc & ~clrT) | 32'(engTcSet)) & ((32'd1 << NCH) - 1);
      mErr = ((mErr & ~clrE) | 32'(engErrSet)) & ((32'd1 << NCH) - 1);
      for (int c = 0; c < NCH; c++) if (engChanDone[c]) mReg[c][4][0] = 1'b0;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (busRdata !== expRd) begin
        errors++;
        $display("FAIL R1 busRdata per-cycle: actual=%h expected=%h", busRdata, expRd);
      end
      checks++;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL R10 irqOut per-cycle: actual=%b expected=%b", irqOut, mIrq);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic readChk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    chk(tag, busRdata, exp);
  endtask

  task automatic pulse(logic [NCH-1:0] t, logic [NCH-1:0] e, logic [NCH-1:0] d);
    @(negedge clk);
    engTcSet = t; engErrSet = e; engChanDone = d;
    @(negedge clk);
    engTcSet = 0; engErrSet = 0; engChanDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset irqOut", 32'(irqOut), 0);
    chk("R8 reset ctlEn", 32'(ctlEn), 0);
    readChk(12'h110, 0, "R1 reset ch0 config");
    readChk(12'h014, 0, "R1 reset raw tc");

    // R1 channel word layout
    busWr(12'h100, 32'hA000_0001);
    busWr(12'h104, 32'hB000_0002);
    busWr(12'h108, 32'hC000_0003);
    busWr(12'h10C, 32'hD000_0004);
    busWr(12'h1A0, 32'h5555_AAAA);
    readChk(12'h100, 32'hA000_0001, "R1 ch0 source");
    readChk(12'h104, 32'hB000_0002, "R1 ch0 destination");
    readChk(12'h108, 32'hC000_0003, "R1 ch0 link");
    readChk(12'h10C, 32'hD000_0004, "R1 ch0 control");
    readChk(12'h1A0, 32'h5555_AAAA, "R1 ch5 source");
    readChk(12'h1A4, 0, "R1 ch5 destination untouched");

    // R2 out-of-range channel and word slots
    busWr(12'h1C0, 32'h1234_5678);
    busWr(12'h1E4, 32'h1234_5678);
    busWr(12'h114, 32'hFFFF_FFFF);
    readChk(12'h1C0, 0, "R2 ch6 ignored");
    readChk(12'h1E4, 0, "R2 ch7 ignored");
    readChk(12'h114, 0, "R2 word5 ignored");
    readChk(12'h110, 0, "R2 ch0 config untouched");

    // R3 raw latches
    pulse(6'b000101, 6'b100000, 6'b0);
    readChk(12'h014, 32'h5, "R3 raw tc");
    readChk(12'h018, 32'h20, "R3 raw error");
    readChk(12'h000, 0, "R4 combined with masks off");
    chk("R10 irq low with masks off", 32'(irqOut), 0);

    // R4 masks from config bits 15/14
    busWr(12'h110, 32'h0000_8000);
    readChk(12'h004, 32'h1, "R4 masked tc");
    readChk(12'h00C, 0, "R4 masked error before mask");
    busWr(12'h1B0, 32'h0000_4000);
    readChk(12'h00C, 32'h20, "R4 masked error");
    readChk(12'h000, 32'h21, "R4 combined status");
    chk("R10 irq high", 32'(irqOut), 1);

    // R5 write-one-to-clear
    busWr(12'h008, 32'h1);
    readChk(12'h014, 32'h4, "R5 tc clear");
    busWr(12'h010, 32'h20);
    readChk(12'h018, 0, "R5 error clear");
    @(negedge clk);
    chk("R10 irq low after clears", 32'(irqOut), 0);

    // R6 set wins over simultaneous clear
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 12'h008; busWdata = 32'h6; engTcSet = 6'b000010;
    @(negedge clk);
    busSel = 0; busWrite = 0; engTcSet = 0;
    readChk(12'h014, 32'h2, "R6 set beats clear");

    // R7 enabled bitmap and done pulses
    busWr(12'h110, 32'h0000_8001);
    busWr(12'h130, 32'h1);
    readChk(12'h01C, 32'h3, "R7 enabled bitmap");
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 12'h130; busWdata = 32'h0000_0011; engChanDone = 6'b000010;
    @(negedge clk);
    busSel = 0; busWrite = 0; engChanDone = 0;
    readChk(12'h130, 32'h0000_0010, "R7 done beats write");
    pulse(0, 0, 6'b000001);
    readChk(12'h110, 32'h0000_8000, "R7 done clears enable");
    readChk(12'h01C, 0, "R7 bitmap empty");

    // R8 global configuration
    busWr(12'h030, 32'hFFFF_FFFF);
    readChk(12'h030, 32'h7, "R8 config bits");
    chk("R8 ctlEn high", 32'(ctlEn), 1);
    busWr(12'h030, 32'h6);
    chk("R8 ctlEn low", 32'(ctlEn), 0);

    // R9 identification bytes
    for (int i = 0; i < 8; i++)
      readChk(12'hFE0 + 12'(4 * i), {24'h0, idM(i)}, "R9 id byte");
    chk("R9 first id byte value", 32'(idM(0)), 32'h81);

    // R11 unmapped offsets
    busWr(12'h020, 32'hFFFF_FFFF);
    busWr(12'h800, 32'hFFFF_FFFF);
    busWr(12'h008 + 12'h200, 32'hFFFF_FFFF);
    readChk(12'h020, 0, "R11 soft word reads zero");
    readChk(12'h800, 0, "R11 high offset reads zero");
    readChk(12'h040, 0, "R11 global word 16 reads zero");
    readChk(12'h014, 32'h2, "R11 latches unchanged");
    readChk(12'h030, 32'h6, "R11 config unchanged");

    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule